// File: doc/BRIEF.md
# Page-Mode DRAM Controller with CBR Refresh

This block drives an asynchronous, second-generation DRAM from a synchronous request port. Each request carries a full word address. The controller splits that address into a row half and a column half and places them one after the other on a shared, narrower address bus. The row is strobed with the row strobe, and the column with the column strobe. Reads return data one cycle after the column pulse ends, and writes drive the data bus while the column strobe is low.

After an access the row stays open. A later request to the same row pulses only the column strobe (fast page mode). A request to a different row first releases the row strobe and holds it high for a programmable precharge time.

A free-running interval counter raises a refresh demand every `cfg_refi` clock cycles. The demand takes priority over new requests at the next access boundary. The controller closes any open row, precharges it, and then issues a CAS-before-RAS refresh, which needs no row address from the controller. The RAS-to-CAS delay, the column pulse width and the precharge time are all programmable cycle counts.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `rd_valid` is low and `req_ready` is high.
- R2: The row is the upper ROW_W bits of `req_addr` and the column is the lower COL_W bits. The row is on `dram_addr` when `dram_ras_n` falls, and the column is on `dram_addr` when `dram_cas_n` falls with the row strobe low.
- R3: On a write, `dram_we_n` is low, `dram_dq_oe` is high and `dram_dq_out` holds the request data while the column strobe is low. On a read, `dram_oe_n` is low instead, and `rd_valid` pulses for one cycle carrying the word the memory returned. `dram_we_n` and `dram_oe_n` are never low together.
- R4: At least `cfg_trcd` clock cycles pass between the fall of `dram_ras_n` and the next fall of `dram_cas_n` for an access.
- R5: For an access, `dram_cas_n` stays low for exactly `cfg_tcas` cycles.
- R6: A request to the row that is already open pulses only the column strobe. The row strobe stays low and is not pulsed again.
- R7: The row strobe is high for at least `cfg_trp` cycles before each fall. A request to a different row closes the open row first.
- R8: A refresh is a fall of `dram_cas_n` while `dram_ras_n` is high. Consecutive refreshes are at most `cfg_refi` cycles plus one access time apart.
- R9: A due refresh goes ahead of waiting requests and cannot be starved by a steady stream of page hits. The open row is closed and precharged for `cfg_trp` cycles before the refresh.
- R10: After a refresh no row is open, so the next access does a full row activation even if it targets the previously open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_trcd | input | CNT_W | RAS-to-CAS delay in cycles |
| cfg_tcas | input | CNT_W | Column strobe low time in cycles |
| cfg_trp | input | CNT_W | Precharge (row strobe high) time in cycles |
| cfg_refi | input | REF_W | Refresh interval in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench goes after the row-hit and row-miss boundary. If the page comparison were wrong, every access would re-activate the row, or a different row would be read without a new activation, and data would land in the wrong cell. It also targets the refresh path under an unbroken stream of page hits. A controller that let requests win would stretch the gap between refreshes beyond the interval, and one that did not precharge first would strobe CAS into an open row. A refresh followed by an access to the old row is also probed, because a stale open-row flag would skip the activation. Strobe spacings are measured against the programmed delays, so an off-by-one counter shows up as a short or long pulse.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACT  = 3'd1,
      ST_CAS  = 3'd2,
      ST_OPEN = 3'd3,
      ST_PRE  = 3'd4,
      ST_RCAS = 3'd5,
      ST_RRAS = 3'd6
   } seq_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int REF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REF_W-1:0] cfg_refi,
   input  logic             ref_ack,
   output logic             ref_pend
);
   logic [REF_W-1:0] tick;
   logic [REF_W:0]   tick_inc;
   logic             expire;

   assign tick_inc = {1'b0, tick} + 1'b1;
   assign expire   = tick_inc >= {1'b0, cfg_refi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick     <= '0;
         ref_pend <= 1'b0;
      end else begin
         tick <= expire ? '0 : tick_inc[REF_W-1:0];
         if (expire)
            ref_pend <= 1'b1;
         else if (ref_ack)
            ref_pend <= 1'b0;
      end
   end

   // R9
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pend && !ref_ack |=> ref_pend);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int ROW_W = 11,
   parameter int COL_W = 11,
   localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic             sel_row,
   input  logic             sel_col,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   output logic [PIN_W-1:0] pins
);
   logic [PIN_W-1:0] row_ext;
   logic [PIN_W-1:0] col_ext;

   generate
      if (ROW_W == PIN_W) begin : g_row_full
         assign row_ext = row;
      end else begin : g_row_pad
         assign row_ext = {{(PIN_W-ROW_W){1'b0}}, row};
      end
      if (COL_W == PIN_W) begin : g_col_full
         assign col_ext = col;
      end else begin : g_col_pad
         assign col_ext = {{(PIN_W-COL_W){1'b0}}, col};
      end
   endgenerate

   always_comb begin
      pins = '0;
      if (sel_row)      pins = row_ext;
      else if (sel_col) pins = col_ext;
   end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
   import dram_ctl_pkg::*;
#(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 11,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8,
   localparam int AW = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_trcd,
   input  logic [CNT_W-1:0]  cfg_tcas,
   input  logic [CNT_W-1:0]  cfg_trp,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   input  logic              ref_pend,
   output logic              ref_ack,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              sel_row,
   output logic              sel_col,
   output logic [ROW_W-1:0]  job_row,
   output logic [COL_W-1:0]  job_col,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in
);
   seq_state_t        st, st_nxt;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W:0]    cnt_inc;
   logic              job_we, job_valid;
   logic [DATA_W-1:0] job_wdata;
   logic [ROW_W-1:0]  open_row, req_row, in_row;
   logic              fire, trcd_done, tcas_done, trp_done;

   assign req_row   = req_addr[AW-1:COL_W];
   assign cnt_inc   = {1'b0, cnt} + 1'b1;
   assign trcd_done = cnt_inc >= {1'b0, cfg_trcd};
   assign tcas_done = cnt_inc >= {1'b0, cfg_tcas};
   assign trp_done  = cnt_inc >= {1'b0, cfg_trp};
   assign req_ready = ((st == ST_IDLE) || (st == ST_OPEN)) && !ref_pend;
   assign fire      = req_valid && req_ready;
   assign in_row    = fire ? req_row : job_row;

   always_comb begin
      st_nxt = st;
      case (st)
         ST_IDLE: if (ref_pend) st_nxt = ST_RCAS;
                  else if (fire) st_nxt = ST_ACT;
         ST_ACT:  if (trcd_done) st_nxt = ST_CAS;
         ST_CAS:  if (tcas_done) st_nxt = ST_OPEN;
         ST_OPEN: if (ref_pend) st_nxt = ST_PRE;
                  else if (fire) st_nxt = (req_row == open_row) ? ST_CAS : ST_PRE;
         ST_PRE:  if (trp_done) begin
                     if (ref_pend)       st_nxt = ST_RCAS;
                     else if (job_valid) st_nxt = ST_ACT;
                     else                st_nxt = ST_IDLE;
                  end
         ST_RCAS: st_nxt = ST_RRAS;
         ST_RRAS: if (tcas_done) st_nxt = ST_PRE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   assign ref_ack = (st_nxt == ST_RCAS) && (st != ST_RCAS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         job_we    <= 1'b0;
         job_valid <= 1'b0;
         job_wdata <= '0;
         job_row   <= '0;
         job_col   <= '0;
         open_row  <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         st       <= st_nxt;
         cnt      <= (st_nxt != st) ? '0 : cnt_inc[CNT_W-1:0];
         rd_valid <= 1'b0;
         if (fire) begin
            job_we    <= req_write;
            job_valid <= 1'b1;
            job_wdata <= req_wdata;
            job_row   <= req_row;
            job_col   <= req_addr[COL_W-1:0];
         end
         if (st_nxt == ST_ACT && st != ST_ACT)
            open_row <= in_row;
         if (st == ST_CAS && st_nxt == ST_OPEN) begin
            job_valid <= 1'b0;
            if (!job_we) begin
               rd_valid <= 1'b1;
               rd_data  <= dq_in;
            end
         end
      end
   end

   assign ras_n   = !((st == ST_ACT) || (st == ST_CAS) || (st == ST_OPEN) || (st == ST_RRAS));
   assign cas_n   = !((st == ST_CAS) || (st == ST_RCAS) || (st == ST_RRAS));
   assign we_n    = !((st == ST_CAS) && job_we);
   assign oe_n    = !((st == ST_CAS) && !job_we);
   assign dq_oe   = (st == ST_CAS) && job_we;
   assign dq_out  = job_wdata;
   assign sel_row = (st == ST_ACT);
   assign sel_col = (st == ST_CAS);

   // strobe spacing observers for the checks below
   logic [CNT_W:0] ras_hi_cnt, ras_lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_hi_cnt <= '1;
         ras_lo_cnt <= '0;
      end else begin
         ras_hi_cnt <= !ras_n ? '0 : ((&ras_hi_cnt) ? ras_hi_cnt : ras_hi_cnt + 1'b1);
         ras_lo_cnt <=  ras_n ? '0 : ((&ras_lo_cnt) ? ras_lo_cnt : ras_lo_cnt + 1'b1);
      end
   end

   // R7
   precharge_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> ras_hi_cnt >= {1'b0, cfg_trp});
   // R4
   ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) && !ras_n |-> ras_lo_cnt >= {1'b0, cfg_trcd});
   // R3
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_n || oe_n);
   // R3
   rd_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !$past(oe_n));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 11,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8,
   parameter int REF_W  = 16,
   localparam int AW    = ROW_W + COL_W,
   localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_trcd,
   input  logic [CNT_W-1:0]  cfg_tcas,
   input  logic [CNT_W-1:0]  cfg_trp,
   input  logic [REF_W-1:0]  cfg_refi,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [PIN_W-1:0]  dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   generate
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
         $error("dram_ctrl: row and column widths must be positive");
      end
      if (CNT_W < 2 || REF_W < 2) begin : g_bad_cnt
         $error("dram_ctrl: counter widths must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dram_ctrl: data width must be positive");
      end
   endgenerate

   logic             ref_pend, ref_ack, sel_row, sel_col;
   logic [ROW_W-1:0] job_row;
   logic [COL_W-1:0] job_col;

   dram_refresh_timer #(.REF_W(REF_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .cfg_refi(cfg_refi),
      .ref_ack(ref_ack), .ref_pend(ref_pend)
   );

   dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_trcd(cfg_trcd), .cfg_tcas(cfg_tcas), .cfg_trp(cfg_trp),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .ref_pend(ref_pend), .ref_ack(ref_ack),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .sel_row(sel_row), .sel_col(sel_col), .job_row(job_row), .job_col(job_col),
      .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
      .dq_out(dram_dq_out), .dq_oe(dram_dq_oe), .dq_in(dram_dq_in)
   );

   dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
      .sel_row(sel_row), .sel_col(sel_col),
      .row(job_row), .col(job_col), .pins(dram_addr)
   );

   // R8
   cbr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) && dram_ras_n |-> dram_we_n && !dram_dq_oe);
endmodule

// File: tb/sim_dram_ctrl.sv
module sim_dram_ctrl;
   localparam int ROW_W = 4, COL_W = 4, DATA_W = 16, CNT_W = 8, REF_W = 16;
   localparam int AW = ROW_W + COL_W;
   localparam int TRCD = 2, TCAS = 2, TRP = 3, REFI = 200, SLACK = 24;
   localparam int WD = 100000;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              req_valid = 1'b0, req_write = 1'b0, req_ready, rd_valid;
   logic [AW-1:0]     req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0, rd_data, dq_out, dq_in;
   logic [ROW_W-1:0]  dram_addr;
   logic              ras_n, cas_n, we_n, oe_n, dq_oe;

   dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REF_W(REF_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_trcd(8'(TRCD)), .cfg_tcas(8'(TCAS)), .cfg_trp(8'(TRP)), .cfg_refi(16'(REFI)),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
      .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // memory model and shadow
   logic [DATA_W-1:0] mem    [0:255];
   logic [DATA_W-1:0] shadow [0:255];
   logic [ROW_W-1:0]  row_l = '0;
   logic [COL_W-1:0]  col_l = '0;
   assign dq_in = (!oe_n && !cas_n && !ras_n) ? mem[{row_l, col_l}] : '0;

   // expected access queue and read queue
   logic [ROW_W-1:0]  q_row [0:1023];
   logic [COL_W-1:0]  q_col [0:1023];
   bit                q_we  [0:1023];
   logic [DATA_W-1:0] q_dat [0:1023];
   logic [DATA_W-1:0] r_dat [0:1023];
   int q_wr = 0, q_rd = 0, r_wr = 0, r_rd = 0;

   // R2 address split: row = addr[AW-1:COL_W], column = addr[COL_W-1:0]
   function automatic logic [ROW_W-1:0] row_of(input logic [AW-1:0] a);
      return a[AW-1:COL_W];
   endfunction
   function automatic logic [COL_W-1:0] col_of(input logic [AW-1:0] a);
      return a[COL_W-1:0];
   endfunction

   // monitor state
   bit  p_ras = 1'b1, p_cas = 1'b1;
   int  hi_cnt = 1000, lo_cnt = 0, cas_lo = 0, cyc = 0, last_ref = 0;
   int  ras_falls = 0, ref_count = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (p_ras && !ras_n && cas_n) begin
            chk(hi_cnt >= TRP, "R7", "ras high cycles before activation", hi_cnt, TRP);
            ras_falls++;
            row_l = dram_addr;
         end
         if (p_cas && !cas_n) begin
            if (ras_n) begin
               chk(p_ras && hi_cnt >= TRP, "R9", "precharge before refresh", hi_cnt, TRP);
               chk(cyc - last_ref <= REFI + SLACK, "R8", "refresh gap", cyc - last_ref, REFI + SLACK);
               last_ref = cyc;
               ref_count++;
            end else begin
               chk(lo_cnt >= TRCD, "R4", "ras-to-cas cycles", lo_cnt, TRCD);
               col_l = dram_addr;
               if (q_rd == q_wr) begin
                  chk(1'b0, "R2", "unexpected access", 0, 1);
               end else begin
                  chk(row_l == q_row[q_rd % 1024], "R2", "row on pins", row_l, q_row[q_rd % 1024]);
                  chk(col_l == q_col[q_rd % 1024], "R2", "column on pins", col_l, q_col[q_rd % 1024]);
                  if (q_we[q_rd % 1024]) begin
                     chk(!we_n && dq_oe && dq_out == q_dat[q_rd % 1024], "R3", "write data",
                         dq_out, q_dat[q_rd % 1024]);
                     mem[{row_l, col_l}] = dq_out;
                  end else begin
                     chk(!oe_n && we_n, "R3", "read strobes", oe_n, 0);
                  end
                  q_rd++;
               end
            end
         end
         if (!p_cas && cas_n && !ras_n)
            chk(cas_lo == TCAS, "R5", "cas low width", cas_lo, TCAS);
         if (rd_valid) begin
            if (r_rd == r_wr) chk(1'b0, "R3", "unexpected read data", 0, 1);
            else begin
               chk(rd_data == r_dat[r_rd % 1024], "R3", "read data", rd_data, r_dat[r_rd % 1024]);
               r_rd++;
            end
         end
         hi_cnt = ras_n ? hi_cnt + 1 : 0;
         lo_cnt = ras_n ? 0 : lo_cnt + 1;
         cas_lo = cas_n ? 0 : cas_lo + 1;
         p_ras = ras_n;
         p_cas = cas_n;
      end
   end

   // called at a negedge; returns at a negedge after acceptance
   task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      q_row[q_wr % 1024] = row_of(a);
      q_col[q_wr % 1024] = col_of(a);
      q_we[q_wr % 1024]  = wr;
      q_dat[q_wr % 1024] = d;
      q_wr++;
      if (wr) shadow[a] = d;
      else begin r_dat[r_wr % 1024] = shadow[a]; r_wr++; end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && (q_rd != q_wr || r_rd != r_wr); i++) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(q_rd == q_wr && r_rd == r_wr, "R3", "all accesses completed", q_rd, q_wr);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int rf0, cnt0;
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes high in reset",
          {ras_n, cas_n, we_n, oe_n}, 15);
      chk(!rd_valid, "R1", "rd_valid low in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes high after reset",
          {ras_n, cas_n, we_n, oe_n}, 15);
      chk(req_ready, "R1", "ready after reset", req_ready, 1);

      // R6 page hits: one activation for three accesses to row 3
      do_req(1'b1, 8'h31, 16'hA5A1);
      do_req(1'b1, 8'h32, 16'h5A52);
      do_req(1'b0, 8'h31, 16'h0);
      drain();
      chk(ras_falls == 1, "R6", "activations for same-row accesses", ras_falls, 1);
      // R7 row miss re-activates
      do_req(1'b1, 8'h50, 16'h1234);
      drain();
      chk(ras_falls == 2, "R7", "activation on row miss", ras_falls, 2);
      // R10 after a refresh the same row needs a new activation
      rf0 = ref_count;
      for (int i = 0; i < 400 && ref_count == rf0; i++) @(negedge clk);
      chk(ref_count > rf0, "R8", "refresh issued while idle", ref_count, rf0 + 1);
      do_req(1'b0, 8'h50, 16'h0);
      drain();
      chk(ras_falls == 3, "R10", "activation after refresh", ras_falls, 3);

      // R9 steady page hits must not starve refresh
      rf0 = ref_count;
      cnt0 = cyc;
      for (int i = 0; i < 300; i++)
         do_req(i[0], {4'h5, 4'(i)}, 16'(i * 7 + 3));
      drain();
      chk(ref_count - rf0 >= (cyc - cnt0) / (REFI + SLACK), "R9", "refreshes during hit stream",
          ref_count - rf0, (cyc - cnt0) / (REFI + SLACK));

      // constrained random mix over a few rows
      for (int i = 0; i < 500; i++) begin
         logic [AW-1:0] a;
         a = {4'($urandom % 4) + 4'd2, 4'($urandom)};
         do_req($urandom % 2 == 0, a, 16'($urandom));
         if ($urandom % 8 == 0) repeat ($urandom % 6) @(negedge clk);
      end
      drain();
      // directed: every column of row 15 read back (R2, R3)
      for (int c = 0; c < 16; c++) do_req(1'b1, {4'hF, 4'(c)}, 16'(16'hF000 + c));
      for (int c = 15; c >= 0; c--) do_req(1'b0, {4'hF, 4'(c)}, 16'h0);
      drain();
      chk(cyc - last_ref <= REFI + SLACK, "R8", "final refresh gap", cyc - last_ref, REFI + SLACK);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule